// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox Pair

This block carries single control words between two ports that run on unrelated clocks, beside (not through) any bulk data path. Mailbox 1 takes a word written on port A and hands it to port B; mailbox 2 does the same from port B to port A. Each mailbox holds one word. The writing side sees an active-low full flag that drops on the edge that stores the word. The reading side sees a ready flag once the word is safe to take. A read on the far side empties the mailbox and, a few writer-clock cycles later, raises the writer's flag again.

Each port has an enable, a mailbox select and a direction select. The two direction selects have opposite senses. On port A a high level means write. On port B a high level means read. Each port also drives an output-enable for an external three-state driver on its read bus, so the bus is released whenever that port has a write selected. Full/empty state crosses between the clocks as one toggle bit per side, each passed through a multi-flop synchronizer. The stored word is only sampled by the other domain once its toggle has settled, and it is held stable until the flag releases.

Top module: `mbx_dual`

## Requirements
- R1: While `rst_n` or `prst_n` is low, and after either one is released, both full flags read 1 (empty), both ready flags read 0 and both read buses read zero.
- R2: A port A access with `a_en`=1, `a_mb`=1 and `a_wr_rd_n`=1 on a rising `clk_a` edge while `a_mb1_full_n`=1 stores `a_din` in mailbox 1 and drives `a_mb1_full_n` to 0 after that edge.
- R3: Port A writes to mailbox 1 while `a_mb1_full_n`=0 are ignored; the word later read on port B is the first word written.
- R4: `b_mb1_ready` rises within 8 `clk_b` cycles of a mailbox 1 write. A port B read (`b_en`=1, `b_mb`=1, `b_rd_wr_n`=1) while it is 1 loads the word onto `b_dout` and drops `b_mb1_ready` after that edge. `a_mb1_full_n` returns to 1 within 8 `clk_a` cycles.
- R5: Mailbox 2 mirrors R2 and R4 in the other direction. A port B write uses `b_rd_wr_n`=0 and drives `b_mb2_full_n` low. `a_mb2_ready` then rises. A port A read uses `a_wr_rd_n`=0, loads `a_dout` and drops `a_mb2_ready`. After that `b_mb2_full_n` returns to 1.
- R6: Port B writes to mailbox 2 while `b_mb2_full_n`=0 are ignored and leave the stored word unchanged.
- R7: A read of a mailbox whose ready flag is 0 leaves that port's read bus and both flags of that mailbox unchanged.
- R8: With the port enable low, or the mailbox select low, an edge makes no mailbox access: no flag changes and no word is stored.
- R9: `a_dout_oe` is 1 exactly when `a_en`=1 and `a_wr_rd_n`=0. `b_dout_oe` is 1 exactly when `b_en`=1 and `b_rd_wr_n`=1.
- R10: The two mailboxes are independent. Writes in both directions at the same time each deliver their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to `clk_a` |
| rst_n | input | 1 | Full reset, active low, asynchronous assertion |
| prst_n | input | 1 | Partial reset, active low; empties both mailboxes |
| a_en | input | 1 | Port A enable |
| a_wr_rd_n | input | 1 | Port A direction: 1 write, 0 read |
| a_mb | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A write word (to mailbox 1) |
| a_dout | output | 36 | Port A read word (from mailbox 2) |
| a_dout_oe | output | 1 | Port A read-bus driver enable |
| a_mb1_full_n | output | 1 | Mailbox 1 full flag, active low, `clk_a` domain |
| a_mb2_ready | output | 1 | Mailbox 2 holds an unread word, `clk_a` domain |
| b_en | input | 1 | Port B enable |
| b_rd_wr_n | input | 1 | Port B direction: 1 read, 0 write |
| b_mb | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B write word (to mailbox 2) |
| b_dout | output | 36 | Port B read word (from mailbox 1) |
| b_dout_oe | output | 1 | Port B read-bus driver enable |
| b_mb2_full_n | output | 1 | Mailbox 2 full flag, active low, `clk_b` domain |
| b_mb1_ready | output | 1 | Mailbox 1 holds an unread word, `clk_b` domain |

## Verification
The hardest case to reach is a write that arrives while the mailbox is still full. This happens both right after the storing edge and during the synchronizer delay after the far side has already read. The stimulus reaches it by issuing a second, different word on the very next writer cycle. It then proves that word was dropped by reading the far side. The clocks are 20 ns and 14.6 ns, so the phase between them drifts across the run. Simultaneous traffic in both directions is started from parallel threads, so that both toggle paths are in flight at once.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_WORD_W      = 36;
    localparam int unsigned MBX_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MBX_IDLE  = 2'd0,
        MBX_WRITE = 2'd1,
        MBX_READ  = 2'd2
    } mbx_acc_e;

    // Decode one port's controls; wr_level is the direction-select level that means write.
    function automatic mbx_acc_e mbx_decode(input logic en, input logic dir,
                                            input logic mb, input logic wr_level);
        mbx_acc_e acc;
        acc = MBX_IDLE;
        if (en && mb) begin
            acc = (dir == wr_level) ? MBX_WRITE : MBX_READ;
        end
        return acc;
    endfunction

endpackage

// File: rtl/mbx_sync_bit.sv
module mbx_sync_bit #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);

    logic [STAGES-1:0] hold_d;
    logic [STAGES-1:0] hold_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb hold_d = 1'b1;
        end else begin : g_chain
            always_comb hold_d = {hold_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign srst_n = hold_q[STAGES-1];

endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int unsigned WORD_W      = MBX_WORD_W,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES,
    parameter bit          WR_LEVEL    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir,
    input  logic              mb,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe,
    output logic              tx_full_n,
    output logic              rx_ready,
    // outgoing mailbox, owned by this clock domain
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_wr_tog,
    input  logic              tx_rd_tog_far,
    // incoming mailbox, owned by the far clock domain
    input  logic [WORD_W-1:0] rx_word_far,
    input  logic              rx_wr_tog_far,
    output logic              rx_rd_tog
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] rdata;
        logic              wr_tog;
        logic              full_n;
        logic              rd_tog;
        logic              ready;
    } port_state_t;

    localparam port_state_t RESET_STATE = '{
        word:   '0,
        rdata:  '0,
        wr_tog: 1'b0,
        full_n: 1'b1,
        rd_tog: 1'b0,
        ready:  1'b0
    };

    port_state_t st_d;
    port_state_t st_q;
    mbx_acc_e    acc;
    logic        do_wr;
    logic        do_rd;
    logic        far_rd_sync;
    logic        far_wr_sync;

    mbx_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tx_rd_tog_far),
        .q     (far_rd_sync)
    );

    mbx_sync_bit #(.STAGES(SYNC_STAGES)) u_sync_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_wr_tog_far),
        .q     (far_wr_sync)
    );

    always_comb begin
        acc   = mbx_decode(en, dir, mb, WR_LEVEL);
        do_wr = (acc == MBX_WRITE) && st_q.full_n;
        do_rd = (acc == MBX_READ) && st_q.ready;

        st_d        = st_q;
        st_d.wr_tog = st_q.wr_tog ^ do_wr;
        st_d.rd_tog = st_q.rd_tog ^ do_rd;
        if (do_wr) begin
            st_d.word = din;
        end
        if (do_rd) begin
            st_d.rdata = rx_word_far;
        end
        // empty once the far reader's toggle has caught up with ours
        st_d.full_n = (st_d.wr_tog == far_rd_sync);
        // mail waiting while the far writer's toggle is ahead of ours
        st_d.ready  = (far_wr_sync != st_d.rd_tog);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = st_q.rdata;
    assign dout_oe   = en && (dir != WR_LEVEL);
    assign tx_full_n = st_q.full_n;
    assign rx_ready  = st_q.ready;
    assign tx_word   = st_q.word;
    assign tx_wr_tog = st_q.wr_tog;
    assign rx_rd_tog = st_q.rd_tog;

endmodule

// File: rtl/mbx_dual.sv
module mbx_dual
    import mbx_pkg::*;
#(
    parameter int unsigned WORD_W      = MBX_WORD_W,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              a_en,
    input  logic              a_wr_rd_n,
    input  logic              a_mb,
    input  logic [WORD_W-1:0] a_din,
    output logic [WORD_W-1:0] a_dout,
    output logic              a_dout_oe,
    output logic              a_mb1_full_n,
    output logic              a_mb2_ready,
    input  logic              b_en,
    input  logic              b_rd_wr_n,
    input  logic              b_mb,
    input  logic [WORD_W-1:0] b_din,
    output logic [WORD_W-1:0] b_dout,
    output logic              b_dout_oe,
    output logic              b_mb2_full_n,
    output logic              b_mb1_ready
);

    logic              any_rst_n;
    logic              rst_a_n;
    logic              rst_b_n;
    logic [WORD_W-1:0] word_ab;
    logic [WORD_W-1:0] word_ba;
    logic              tog_wr_ab;
    logic              tog_rd_ab;
    logic              tog_wr_ba;
    logic              tog_rd_ba;

    // either reset empties both mailboxes
    assign any_rst_n = rst_n & prst_n;

    mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_a (
        .clk    (clk_a),
        .arst_n (any_rst_n),
        .srst_n (rst_a_n)
    );

    mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_b (
        .clk    (clk_b),
        .arst_n (any_rst_n),
        .srst_n (rst_b_n)
    );

    mbx_port #(
        .WORD_W      (WORD_W),
        .SYNC_STAGES (SYNC_STAGES),
        .WR_LEVEL    (1'b1)
    ) u_port_a (
        .clk           (clk_a),
        .rst_n         (rst_a_n),
        .en            (a_en),
        .dir           (a_wr_rd_n),
        .mb            (a_mb),
        .din           (a_din),
        .dout          (a_dout),
        .dout_oe       (a_dout_oe),
        .tx_full_n     (a_mb1_full_n),
        .rx_ready      (a_mb2_ready),
        .tx_word       (word_ab),
        .tx_wr_tog     (tog_wr_ab),
        .tx_rd_tog_far (tog_rd_ab),
        .rx_word_far   (word_ba),
        .rx_wr_tog_far (tog_wr_ba),
        .rx_rd_tog     (tog_rd_ba)
    );

    mbx_port #(
        .WORD_W      (WORD_W),
        .SYNC_STAGES (SYNC_STAGES),
        .WR_LEVEL    (1'b0)
    ) u_port_b (
        .clk           (clk_b),
        .rst_n         (rst_b_n),
        .en            (b_en),
        .dir           (b_rd_wr_n),
        .mb            (b_mb),
        .din           (b_din),
        .dout          (b_dout),
        .dout_oe       (b_dout_oe),
        .tx_full_n     (b_mb2_full_n),
        .rx_ready      (b_mb1_ready),
        .tx_word       (word_ba),
        .tx_wr_tog     (tog_wr_ba),
        .tx_rd_tog_far (tog_rd_ba),
        .rx_word_far   (word_ab),
        .rx_wr_tog_far (tog_wr_ab),
        .rx_rd_tog     (tog_rd_ab)
    );

endmodule

// File: rtl/mbx_dual_chk.sv
module mbx_dual_chk #(
    parameter int unsigned WORD_W = 36
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_n,
    input logic              prst_n,
    input logic              a_en,
    input logic              a_wr_rd_n,
    input logic              a_mb,
    input logic [WORD_W-1:0] a_dout,
    input logic              a_mb1_full_n,
    input logic              a_mb2_ready,
    input logic              b_en,
    input logic              b_rd_wr_n,
    input logic              b_mb,
    input logic [WORD_W-1:0] b_dout,
    input logic              b_mb2_full_n,
    input logic              b_mb1_ready,
    input logic [WORD_W-1:0] word_ab,
    input logic [WORD_W-1:0] word_ba
);

    p_write_drops_flag_r2: assert property (@(posedge clk_a) disable iff (!(rst_n && prst_n))
        (a_en && a_wr_rd_n && a_mb && a_mb1_full_n) |=> !a_mb1_full_n);

    p_full_holds_word_r3: assert property (@(posedge clk_a) disable iff (!(rst_n && prst_n))
        !a_mb1_full_n |=> $stable(word_ab));

    p_read_clears_ready_r4: assert property (@(posedge clk_b) disable iff (!(rst_n && prst_n))
        (b_en && b_rd_wr_n && b_mb && b_mb1_ready) |=> !b_mb1_ready);

    p_read_clears_ready_r5: assert property (@(posedge clk_a) disable iff (!(rst_n && prst_n))
        (a_en && !a_wr_rd_n && a_mb && a_mb2_ready) |=> !a_mb2_ready);

    p_write_drops_flag_r5: assert property (@(posedge clk_b) disable iff (!(rst_n && prst_n))
        (b_en && !b_rd_wr_n && b_mb && b_mb2_full_n) |=> !b_mb2_full_n);

    p_full_holds_word_r6: assert property (@(posedge clk_b) disable iff (!(rst_n && prst_n))
        !b_mb2_full_n |=> $stable(word_ba));

    p_empty_read_keeps_b_r7: assert property (@(posedge clk_b) disable iff (!(rst_n && prst_n))
        (b_en && b_rd_wr_n && b_mb && !b_mb1_ready) |=> $stable(b_dout));

    p_empty_read_keeps_a_r7: assert property (@(posedge clk_a) disable iff (!(rst_n && prst_n))
        (a_en && !a_wr_rd_n && a_mb && !a_mb2_ready) |=> $stable(a_dout));

    p_idle_a_keeps_word_r8: assert property (@(posedge clk_a) disable iff (!(rst_n && prst_n))
        !(a_en && a_mb) |=> $stable(word_ab) && $stable(a_dout));

    p_idle_b_keeps_word_r8: assert property (@(posedge clk_b) disable iff (!(rst_n && prst_n))
        !(b_en && b_mb) |=> $stable(word_ba) && $stable(b_dout));

endmodule

bind mbx_dual mbx_dual_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_mbx_dual.sv
`timescale 1ns/100ps
module tb_mbx_dual;

    localparam int W = 36;

    logic         clk_a, clk_b, rst_n, prst_n;
    logic         a_en, a_wr_rd_n, a_mb;
    logic [W-1:0] a_din, a_dout;
    logic         a_dout_oe, a_mb1_full_n, a_mb2_ready;
    logic         b_en, b_rd_wr_n, b_mb;
    logic [W-1:0] b_din, b_dout;
    logic         b_dout_oe, b_mb2_full_n, b_mb1_ready;

    mbx_dual dut (.*);

    initial clk_a = 1'b0;
    always #10 clk_a = ~clk_a;      // 50 MHz
    initial clk_b = 1'b0;
    always #7.3 clk_b = ~clk_b;     // unrelated

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // {direction (0: A to B, 1: B to A), first word, word attempted while full}
    localparam logic [72:0] VEC [0:5] = '{
        {1'b0, 36'h123456789, 36'hFEDCBA987},
        {1'b1, 36'hA5A5A5A5A, 36'h5A5A5A5A5},
        {1'b0, 36'hFFFFFFFFF, 36'h000000000},
        {1'b1, 36'h800000001, 36'h7FFFFFFFE},
        {1'b0, 36'h0000F0000, 36'h0FFFF0FFF},
        {1'b1, 36'h000000000, 36'hFFFFFFFFF}
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle_a();
        a_en = 0; a_wr_rd_n = 1; a_mb = 0;
    endtask

    task automatic idle_b();
        b_en = 0; b_rd_wr_n = 0; b_mb = 0;
    endtask

    task automatic a_access(input logic en, input logic dir, input logic mb, input logic [W-1:0] d);
        @(negedge clk_a);
        a_en = en; a_wr_rd_n = dir; a_mb = mb; a_din = d;
        @(negedge clk_a);
        idle_a();
    endtask

    task automatic b_access(input logic en, input logic dir, input logic mb, input logic [W-1:0] d);
        @(negedge clk_b);
        b_en = en; b_rd_wr_n = dir; b_mb = mb; b_din = d;
        @(negedge clk_b);
        idle_b();
    endtask

    // wait up to 8 cycles of the named flag's clock for it to reach the wanted level
    task automatic wait_flag(input int which, input logic want, output logic ok);
        ok = 0;
        for (int i = 0; i < 8 && !ok; i++) begin
            case (which)
                0: begin @(negedge clk_b); ok = (b_mb1_ready == want); end
                1: begin @(negedge clk_a); ok = (a_mb1_full_n == want); end
                2: begin @(negedge clk_a); ok = (a_mb2_ready == want); end
                default: begin @(negedge clk_b); ok = (b_mb2_full_n == want); end
            endcase
        end
    endtask

    task automatic do_reset(input bit partial);
        @(negedge clk_a);
        if (partial) prst_n = 0; else rst_n = 0;
        repeat (3) @(negedge clk_a);
        #1;
        chk("R1 full flag A during reset", W'(a_mb1_full_n), W'(1));
        chk("R1 full flag B during reset", W'(b_mb2_full_n), W'(1));
        rst_n = 1; prst_n = 1;
        repeat (4) @(negedge clk_a);
        repeat (4) @(negedge clk_b);
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " a_mb1_full_n"}, W'(a_mb1_full_n), W'(1));
        chk({tag, " b_mb2_full_n"}, W'(b_mb2_full_n), W'(1));
        chk({tag, " a_mb2_ready"},  W'(a_mb2_ready),  W'(0));
        chk({tag, " b_mb1_ready"},  W'(b_mb1_ready),  W'(0));
        chk({tag, " a_dout"}, a_dout, '0);
        chk({tag, " b_dout"}, b_dout, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk_a);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic ok;
        logic [W-1:0] keep;
        rst_n = 1; prst_n = 1;
        a_din = '0; b_din = '0;
        idle_a(); idle_b();
        #5;
        do_reset(0);
        check_reset_state("R1 after full reset");

        // vector table: write, blocked overwrite, delivery, release
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] w1, w2;
            w1 = VEC[i][71:36];
            w2 = VEC[i][35:0];
            if (!VEC[i][72]) begin
                a_access(1, 1, 1, w1);
                chk("R2 flag low after write", W'(a_mb1_full_n), W'(0));
                a_access(1, 1, 1, w2);
                chk("R3 flag still low after blocked write", W'(a_mb1_full_n), W'(0));
                wait_flag(0, 1, ok);
                chk("R4 b_mb1_ready rises", W'(ok), W'(1));
                b_access(1, 1, 1, '0);
                chk("R3 delivered word is the first", b_dout, w1);
                chk("R4 ready drops after read", W'(b_mb1_ready), W'(0));
                wait_flag(1, 1, ok);
                chk("R4 a_mb1_full_n returns high", W'(ok), W'(1));
            end else begin
                b_access(1, 0, 1, w1);
                chk("R5 flag low after B write", W'(b_mb2_full_n), W'(0));
                b_access(1, 0, 1, w2);
                chk("R6 flag still low after blocked write", W'(b_mb2_full_n), W'(0));
                wait_flag(2, 1, ok);
                chk("R5 a_mb2_ready rises", W'(ok), W'(1));
                a_access(1, 0, 1, '0);
                chk("R6 delivered word is the first", a_dout, w1);
                chk("R5 ready drops after read", W'(a_mb2_ready), W'(0));
                wait_flag(3, 1, ok);
                chk("R5 b_mb2_full_n returns high", W'(ok), W'(1));
            end
        end

        // R7: empty reads change nothing
        keep = b_dout;
        b_access(1, 1, 1, '0);
        chk("R7 b_dout unchanged on empty read", b_dout, keep);
        chk("R7 b_mb1_ready stays low", W'(b_mb1_ready), W'(0));
        keep = a_dout;
        a_access(1, 0, 1, '0);
        chk("R7 a_dout unchanged on empty read", a_dout, keep);
        chk("R7 a_mb1_full_n stays high", W'(a_mb1_full_n), W'(1));

        // R8: disabled port or no mailbox select
        a_access(0, 1, 1, 36'h111111111);
        chk("R8 enable low: no write", W'(a_mb1_full_n), W'(1));
        a_access(1, 1, 0, 36'h222222222);
        chk("R8 select low: no write", W'(a_mb1_full_n), W'(1));
        b_access(1, 0, 0, 36'h333333333);
        chk("R8 select low: no B write", W'(b_mb2_full_n), W'(1));
        wait_flag(0, 1, ok);
        chk("R8 nothing reached port B", W'(ok), W'(0));

        // R9: output-enable polarity per port
        @(negedge clk_a);
        a_en = 1; a_wr_rd_n = 0; #1 chk("R9 a_oe read", W'(a_dout_oe), W'(1));
        a_wr_rd_n = 1; #1 chk("R9 a_oe write", W'(a_dout_oe), W'(0));
        a_en = 0; a_wr_rd_n = 0; #1 chk("R9 a_oe disabled", W'(a_dout_oe), W'(0));
        idle_a();
        @(negedge clk_b);
        b_en = 1; b_rd_wr_n = 1; #1 chk("R9 b_oe read", W'(b_dout_oe), W'(1));
        b_rd_wr_n = 0; #1 chk("R9 b_oe write", W'(b_dout_oe), W'(0));
        b_en = 0; b_rd_wr_n = 1; #1 chk("R9 b_oe disabled", W'(b_dout_oe), W'(0));
        idle_b();

        // R10: both directions at once
        fork
            a_access(1, 1, 1, 36'hC0FFEE123);
            b_access(1, 0, 1, 36'hBEEF00456);
        join
        fork
            begin
                logic okb;
                wait_flag(0, 1, okb);
                b_access(1, 1, 1, '0);
            end
            begin
                logic oka;
                wait_flag(2, 1, oka);
                a_access(1, 0, 1, '0);
            end
        join
        chk("R10 word A to B", b_dout, 36'hC0FFEE123);
        chk("R10 word B to A", a_dout, 36'hBEEF00456);

        // R1: partial reset empties a full mailbox
        a_access(1, 1, 1, 36'h0DEADBEEF);
        chk("R2 full before partial reset", W'(a_mb1_full_n), W'(0));
        do_reset(1);
        check_reset_state("R1 after partial reset");

        finish_run();
    end

endmodule